// File: doc/BRIEF.md
# Four-Unit Crossbar Datapath

This block is a small programmable datapath made of four function units. Each unit computes one result per clock and keeps it in its own result register. A common pool of operands feeds every unit: the four registered results, one external data word and two constant words that are fixed by parameters. Every cycle the caller supplies a pair of source addresses for each unit. The pair picks the two operands of that unit from the pool, and the two picks are made independently of each other.

Unit 0 is the only programmable unit. A two-bit opcode sets its operation: logical left shift, bitwise XOR, or equality test. Units 1, 2 and 3 have fixed operations: add, subtract and multiply. All results keep only the low bits, at the data width. The block's output is the result register of unit 3.

A surrounding controller uses the block by driving a stream of source-address words and opcodes, one per cycle. It feeds values in through the external data word and reads the final value from the output. To see an intermediate result, it routes that result through unit 3. Because every unit reads only registered results, all four registers load at the same edge, and no unit sees a value that another unit produces in the same cycle.

Top module: `mfu_datapath`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, every clock edge clears all four result registers to 0, so the output reads 0 one edge after reset is sampled.
- R2: `result_out` is the result register of unit 3. Any input change reaches it only after the next rising clock edge, and it does not change between edges.
- R3: A 3-bit source address selects an operand as follows: values 0 to 3 pick the registered result of units 0 to 3, 4 picks `data_in`, 5 picks constant `CONST0`, 6 picks constant `CONST1`, and 7 yields zero.
- R4: Unit i takes its first operand from bits [3i+2:3i] of `sel_a` and its second operand from bits [3i+2:3i] of `sel_b`. The two addresses may differ or be equal, and each is decoded independently.
- R5: Unit 1 loads (a + b) truncated to W bits.
- R6: Unit 2 loads (a - b) truncated to W bits, wrapping modulo 2^W.
- R7: Unit 3 loads the low W bits of a * b.
- R8: With opcode 0, unit 0 loads a shifted left logically by b positions. The result is 0 when b is W or more.
- R9: With opcode 1, unit 0 loads a XOR b.
- R10: With opcode 2, unit 0 loads 1 when a equals b and 0 otherwise.
- R11: With opcode 3, unit 0 loads 0.
- R12: All four units sample the operand pool as it stood before the edge, so a unit that reads another unit's result gets that unit's value from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | W | External operand word (source 4) |
| sel_a | input | 4*3 | First-operand source address per unit, unit i at [3i+2:3i] |
| sel_b | input | 4*3 | Second-operand source address per unit, unit i at [3i+2:3i] |
| opcode | input | 2 | Operation of unit 0: 0 shift, 1 XOR, 2 equal, 3 zero |
| result_out | output | W | Registered result of unit 3 |

## Verification
Each unit result is due exactly one rising edge after the inputs that produce it. The output shows unit 3 directly, so it follows its stimulus after one edge. A result of units 0 to 2 becomes visible only when a later cycle routes it through unit 3, which adds one more edge. The driver applies inputs on the falling edge and pushes the expected output for the following rising edge into a queue. The monitor takes one item from the queue a moment after each rising edge. Also, right after each new stimulus is driven, the output is compared with the value from the previous edge, to confirm that nothing passes through combinationally.

// File: rtl/mfu_pkg.sv
package mfu_pkg;

   localparam int unsigned NUM_FU    = 4;
   localparam int unsigned SEL_W     = 3;
   localparam int unsigned NUM_SRC   = 1 << SEL_W;
   localparam int unsigned OPC_W     = 2;

   localparam logic [SEL_W-1:0] SRC_EXT  = 3'd4;
   localparam logic [SEL_W-1:0] SRC_K0   = 3'd5;
   localparam logic [SEL_W-1:0] SRC_K1   = 3'd6;
   localparam logic [SEL_W-1:0] SRC_NULL = 3'd7;

   typedef enum logic [OPC_W-1:0] {
      OPC_SHL  = 2'd0,
      OPC_XOR  = 2'd1,
      OPC_EQ   = 2'd2,
      OPC_NONE = 2'd3
   } mfu_opc_e;

   typedef enum int unsigned {
      UNIT_PROG = 0,
      UNIT_ADD  = 1,
      UNIT_SUB  = 2,
      UNIT_MUL  = 3
   } mfu_kind_e;

endpackage

// File: rtl/mfu_src_bank.sv
module mfu_src_bank
   import mfu_pkg::*;
#(
   parameter int unsigned   W      = 16,
   parameter logic [W-1:0]  CONST0 = '0,
   parameter logic [W-1:0]  CONST1 = W'(1)
) (
   input  logic [NUM_FU*W-1:0]  fu_q_flat,
   input  logic [W-1:0]         data_in,
   output logic [NUM_SRC*W-1:0] src_flat
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
         if (gi < NUM_FU) begin : g_fu
            assign src_flat[gi*W +: W] = fu_q_flat[gi*W +: W];
         end else if (gi == int'(SRC_EXT)) begin : g_ext
            assign src_flat[gi*W +: W] = data_in;
         end else if (gi == int'(SRC_K0)) begin : g_k0
            assign src_flat[gi*W +: W] = CONST0;
         end else if (gi == int'(SRC_K1)) begin : g_k1
            assign src_flat[gi*W +: W] = CONST1;
         end else begin : g_zero
            assign src_flat[gi*W +: W] = '0;
         end
      end
   endgenerate

endmodule

// File: rtl/mfu_operand_sel.sv
module mfu_operand_sel
   import mfu_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [NUM_SRC*W-1:0] src_flat,
   input  logic [SEL_W-1:0]     sel,
   output logic [W-1:0]         operand
);

   always_comb begin
      operand = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (sel == SEL_W'(k)) begin
            operand = src_flat[k*W +: W];
         end
      end
   end

endmodule

// File: rtl/mfu_unit.sv
module mfu_unit
   import mfu_pkg::*;
#(
   parameter int unsigned W    = 16,
   parameter mfu_kind_e   KIND = UNIT_ADD
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_SRC*W-1:0] src_flat,
   input  logic [SEL_W-1:0]     sel_a,
   input  logic [SEL_W-1:0]     sel_b,
   input  logic [OPC_W-1:0]     opcode,
   output logic [W-1:0]         q
);

   localparam logic [W-1:0] WIDTH_AS_VAL = W[W-1:0];

   logic [W-1:0] opnd_a;
   logic [W-1:0] opnd_b;
   logic [W-1:0] res_d;

   mfu_operand_sel #(.W(W)) u_sel_a (
      .src_flat (src_flat),
      .sel      (sel_a),
      .operand  (opnd_a)
   );

   mfu_operand_sel #(.W(W)) u_sel_b (
      .src_flat (src_flat),
      .sel      (sel_b),
      .operand  (opnd_b)
   );

   generate
      if (KIND == UNIT_PROG) begin : g_prog
         mfu_opc_e opc;
         assign opc = mfu_opc_e'(opcode);
         always_comb begin
            unique case (opc)
               OPC_SHL: begin
                  if (opnd_b >= WIDTH_AS_VAL) res_d = '0;
                  else                        res_d = opnd_a << opnd_b;
               end
               OPC_XOR: res_d = opnd_a ^ opnd_b;
               OPC_EQ:  res_d = {{(W-1){1'b0}}, (opnd_a == opnd_b)};
               default: res_d = '0;
            endcase
         end
      end else begin : g_fixed
         logic unused_opcode;
         assign unused_opcode = ^opcode;
         if (KIND == UNIT_ADD) begin : g_add
            assign res_d = opnd_a + opnd_b;
         end else if (KIND == UNIT_SUB) begin : g_sub
            assign res_d = opnd_a - opnd_b;
         end else begin : g_mul
            logic [2*W-1:0] prod;
            logic [W-1:0]   unused_prod_hi;
            assign prod           = opnd_a * opnd_b;
            assign unused_prod_hi = prod[2*W-1:W];
            assign res_d          = prod[W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= res_d;
   end

endmodule

// File: rtl/mfu_datapath.sv
module mfu_datapath
   import mfu_pkg::*;
#(
   parameter int unsigned   W      = 16,
   parameter logic [W-1:0]  CONST0 = '0,
   parameter logic [W-1:0]  CONST1 = W'(1)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [W-1:0]            data_in,
   input  logic [NUM_FU*SEL_W-1:0] sel_a,
   input  logic [NUM_FU*SEL_W-1:0] sel_b,
   input  logic [OPC_W-1:0]        opcode,
   output logic [W-1:0]            result_out
);

   localparam int unsigned LAST_FU = NUM_FU - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("mfu_datapath: W must be at least 2");
      end
      if (NUM_FU > (1 << SEL_W) - 3) begin : g_bad_count
         $error("mfu_datapath: address space too small for units and constants");
      end
   endgenerate

   logic [NUM_FU*W-1:0]  fu_q_flat;
   logic [NUM_SRC*W-1:0] src_flat;

   mfu_src_bank #(.W(W), .CONST0(CONST0), .CONST1(CONST1)) u_bank (
      .fu_q_flat (fu_q_flat),
      .data_in   (data_in),
      .src_flat  (src_flat)
   );

   genvar gu;
   generate
      for (gu = 0; gu < NUM_FU; gu++) begin : g_unit
         mfu_unit #(.W(W), .KIND(mfu_kind_e'(gu))) u_fu (
            .clk      (clk),
            .rst      (rst),
            .src_flat (src_flat),
            .sel_a    (sel_a[gu*SEL_W +: SEL_W]),
            .sel_b    (sel_b[gu*SEL_W +: SEL_W]),
            .opcode   (opcode),
            .q        (fu_q_flat[gu*W +: W])
         );
      end
   endgenerate

   assign result_out = fu_q_flat[LAST_FU*W +: W];

endmodule

// File: rtl/mfu_datapath_chk.sv
module mfu_datapath_chk
   import mfu_pkg::*;
#(
   parameter int unsigned  W      = 16,
   parameter logic [W-1:0] CONST0 = '0
) (
   input logic                    clk,
   input logic                    rst,
   input logic [W-1:0]            data_in,
   input logic [NUM_FU*SEL_W-1:0] sel_a,
   input logic [NUM_FU*SEL_W-1:0] sel_b,
   input logic [OPC_W-1:0]        opcode,
   input logic [W-1:0]            result_out,
   input logic [NUM_FU*W-1:0]     fu_q_flat
);

   // R1
   reset_clears_chk: assert property (@(posedge clk) rst |=> (result_out == '0 && fu_q_flat == '0));

   // R3
   ext_plus_k0_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_a[5:3] == SRC_EXT && sel_b[5:3] == SRC_K0)
      |=> fu_q_flat[W +: W] == W'($past(data_in) + CONST0));

   // R8
   shift_of_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode == OPC_SHL && sel_a[2:0] == SRC_NULL) |=> fu_q_flat[0 +: W] == '0);

   // R9
   xor_self_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode == OPC_XOR && sel_a[2:0] == sel_b[2:0]) |=> fu_q_flat[0 +: W] == '0);

   // R10
   eq_self_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode == OPC_EQ && sel_a[2:0] == sel_b[2:0]) |=> fu_q_flat[0 +: W] == W'(1));

   // R11
   idle_opcode_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode == OPC_NONE) |=> fu_q_flat[0 +: W] == '0);

endmodule

bind mfu_datapath mfu_datapath_chk #(.W(W), .CONST0(CONST0)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .data_in    (data_in),
   .sel_a      (sel_a),
   .sel_b      (sel_b),
   .opcode     (opcode),
   .result_out (result_out),
   .fu_q_flat  (fu_q_flat)
);

// File: tb/mfu_datapath_tb.sv
module mfu_datapath_tb;

   localparam int           CLK_PERIOD = 10;
   localparam int           W          = 16;
   localparam logic [15:0]  K0         = 16'h0000;
   localparam logic [15:0]  K1         = 16'h0001;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] data_in = '0;
   logic [11:0] sel_a = '0;
   logic [11:0] sel_b = '0;
   logic [1:0]  opcode = '0;
   logic [15:0] result_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic [15:0] mdl [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   mfu_datapath #(.W(W), .CONST0(K0), .CONST1(K1)) u_dut (
      .clk        (clk),
      .rst        (rst),
      .data_in    (data_in),
      .sel_a      (sel_a),
      .sel_b      (sel_b),
      .opcode     (opcode),
      .result_out (result_out)
   );

   function automatic logic [11:0] pk(int s0, int s1, int s2, int s3);
      return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
   endfunction

   function automatic logic [15:0] pick(int s, logic [15:0] din);
      case (s)
         0, 1, 2, 3: return mdl[s];
         4: return din;
         5: return K0;
         6: return K1;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic report_summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Driver: new inputs on the falling edge, expected output for the next rising edge queued.
   task automatic apply(logic [11:0] sa, logic [11:0] sb, logic [1:0] op,
                        logic [15:0] din, string req);
      logic [15:0] a [4];
      logic [15:0] b [4];
      logic [15:0] nxt [4];
      logic [31:0] prod;
      @(negedge clk);
      rst = 1'b0; sel_a = sa; sel_b = sb; opcode = op; data_in = din;
      for (int i = 0; i < 4; i++) begin
         a[i] = pick(int'(sa[3*i +: 3]), din);
         b[i] = pick(int'(sb[3*i +: 3]), din);
      end
      case (op)
         2'd0: nxt[0] = (b[0] >= 16) ? 16'h0 : 16'(a[0] << b[0]);
         2'd1: nxt[0] = a[0] ^ b[0];
         2'd2: nxt[0] = (a[0] == b[0]) ? 16'h1 : 16'h0;
         default: nxt[0] = 16'h0;
      endcase
      nxt[1] = 16'(a[1] + b[1]);
      nxt[2] = 16'(a[2] - b[2]);
      prod   = a[3] * b[3];
      nxt[3] = prod[15:0];
      #1;
      // R2: no combinational path from inputs to the output
      check("R2", result_out, mdl[3]);
      for (int i = 0; i < 4; i++) mdl[i] = nxt[i];
      exp_q.push_back(nxt[3]);
      tag_q.push_back(req);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 4; i++) mdl[i] = '0;
      exp_q.push_back(16'h0);
      tag_q.push_back("R1");
   endtask

   // Monitor: compare a moment after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [15:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, result_out, e);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report_summary();
   end

   initial begin
      for (int i = 0; i < 4; i++) mdl[i] = '0;
      apply_reset();
      apply_reset();
      // R3 R7: unit 3 squares data_in; unit 1 = data_in + const1
      apply(pk(7, 4, 7, 4), pk(7, 6, 7, 4), 2'd3, 16'd7, "R7");
      // R5 R12: unit 3 reads unit 1 (8) times const1; unit 1 counts on from its old value
      apply(pk(7, 1, 7, 1), pk(7, 6, 7, 6), 2'd3, 16'd0, "R5");
      apply(pk(7, 1, 7, 1), pk(7, 6, 7, 6), 2'd3, 16'd0, "R12");
      // R6 R4: unit 2 = data_in - unit1 (wraps), then show it; swap operands next
      apply(pk(7, 7, 4, 7), pk(7, 7, 1, 7), 2'd3, 16'd3, "R6");
      apply(pk(7, 7, 1, 2), pk(7, 7, 4, 6), 2'd3, 16'd3, "R6");
      apply(pk(7, 7, 7, 2), pk(7, 7, 7, 6), 2'd3, 16'd0, "R4");
      // R8: shift by 1, by 15, by 16 and by a large value
      apply(pk(4, 7, 7, 7), pk(6, 7, 7, 7), 2'd0, 16'h00A5, "R8");
      apply(pk(7, 7, 7, 0), pk(7, 7, 7, 6), 2'd3, 16'd0, "R8");
      apply(pk(6, 7, 7, 7), pk(4, 7, 7, 7), 2'd0, 16'd15, "R8");
      apply(pk(7, 7, 7, 0), pk(7, 7, 7, 6), 2'd3, 16'd0, "R8");
      apply(pk(6, 7, 7, 7), pk(4, 7, 7, 7), 2'd0, 16'd16, "R8");
      apply(pk(7, 7, 7, 0), pk(7, 7, 7, 6), 2'd3, 16'd0, "R8");
      apply(pk(6, 7, 7, 7), pk(4, 7, 7, 7), 2'd0, 16'hF003, "R8");
      apply(pk(7, 7, 7, 0), pk(7, 7, 7, 6), 2'd3, 16'd0, "R8");
      // R9: XOR
      apply(pk(4, 7, 7, 7), pk(6, 7, 7, 7), 2'd1, 16'h5A5A, "R9");
      apply(pk(7, 7, 7, 0), pk(7, 7, 7, 6), 2'd3, 16'd0, "R9");
      // R10: equal and unequal
      apply(pk(4, 7, 7, 7), pk(4, 7, 7, 7), 2'd2, 16'h1234, "R10");
      apply(pk(7, 7, 7, 0), pk(7, 7, 7, 6), 2'd3, 16'd0, "R10");
      apply(pk(4, 7, 7, 7), pk(5, 7, 7, 7), 2'd2, 16'd5, "R10");
      apply(pk(7, 7, 7, 0), pk(7, 7, 7, 6), 2'd3, 16'd0, "R10");
      // R11: reserved opcode gives 0 even with nonzero operands
      apply(pk(4, 7, 7, 7), pk(6, 7, 7, 7), 2'd3, 16'hBEEF, "R11");
      apply(pk(7, 7, 7, 0), pk(7, 7, 7, 6), 2'd3, 16'd0, "R11");
      // R3: address 7 yields zero, constants 5 and 6
      apply(pk(7, 7, 7, 4), pk(7, 7, 7, 7), 2'd3, 16'hFFFF, "R3");
      apply(pk(7, 5, 7, 6), pk(7, 4, 7, 6), 2'd3, 16'd9, "R3");
      apply(pk(7, 7, 7, 1), pk(7, 7, 7, 6), 2'd3, 16'd0, "R3");
      // R7: multiply truncation
      apply(pk(7, 7, 7, 4), pk(7, 7, 7, 4), 2'd3, 16'h1234, "R7");
      // R12: all units cross-read each other at once
      apply(pk(4, 4, 4, 4), pk(6, 6, 6, 4), 2'd1, 16'd21, "R12");
      apply(pk(1, 0, 3, 2), pk(2, 3, 0, 1), 2'd1, 16'd0, "R12");
      apply(pk(1, 0, 3, 2), pk(2, 3, 0, 1), 2'd1, 16'd0, "R12");
      // R1: reset mid-run clears every unit
      apply_reset();
      apply(pk(0, 1, 2, 3), pk(6, 6, 6, 6), 2'd1, 16'd0, "R1");
      apply(pk(7, 0, 1, 2), pk(7, 6, 6, 6), 2'd3, 16'd0, "R1");
      @(negedge clk);
      @(negedge clk);
      report_summary();
   end

endmodule